// File: doc/BRIEF.md
# Multi-Level Trigger Sequencer

This block is the control engine that carries one accepted event through the levels of a staged trigger. A prescaled first-level accept arms it. It then opens the beam and detector gates for the digitizers, starts the second-level decision and raises a deadtime level that keeps the trigger frozen. After that it waits for the second-level verdict.

A rejection, or a verdict that never arrives within a programmed limit, leads straight to a front-end reset pulse. This reset restarts the time digitizers and clears the charge digitizers, and the downstream processors are not disturbed. An acceptance pulses a start to the third-level processing master. The sequencer then waits, for as long as needed, for that master to report that readout is done. Both paths end the same way: a reset pulse, a fixed settle interval, and then deadtime drops so the trigger is re-armed.

All durations are parameters counted in clock cycles. A parameter also selects whether the second-level timeout exists at all.

Top module: `evt_level_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every output is low.
- R2: When idle (`dead` low), a high `l0_accept` at a clock edge makes `beam_gate`, `det_gate` and `l1_go` high for exactly STROBE_CYC cycles starting the following cycle, and `dead` rises in that same cycle.
- R3: `dead` stays high without a gap from the cycle after the accept until the last settle cycle, on every path. It falls only right after SETTLE_CYC settle cycles.
- R4: The level-1 inputs are ignored while the gates are open. The verdict is taken only at edges after `l1_go` has fallen.
- R5: A verdict with `l1_valid` high and `l1_pass` low makes `fe_reset` high for RESET_CYC cycles starting the next cycle. `l2_go` stays low on this path.
- R6: A verdict with `l1_valid` and `l1_pass` both high makes `l2_go` high for exactly one cycle starting the next cycle. After that no reset comes until `l2_clear` arrives, however long that takes.
- R7: `l2_clear` during the wait after `l2_go` makes `fe_reset` high for RESET_CYC cycles starting the next cycle. SETTLE_CYC cycles with `dead` high and all other outputs low follow.
- R8: With the timeout enabled, if no verdict has arrived after L1_TIMEOUT_CYC cycles of waiting, `fe_reset` rises in the next cycle. A verdict sampled on that last waiting cycle takes priority over the timeout.
- R9: `l0_accept` while `dead` is high, and `l2_clear` outside the wait for it, have no effect on any output.
- R10: An `l0_accept` in the first cycle after `dead` falls is accepted.
- R11: At most one of `l1_go`, `l2_go` and `fe_reset` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l0_accept | input | 1 | Prescaled first-level accept |
| l1_valid | input | 1 | Second-level verdict present |
| l1_pass | input | 1 | Second-level verdict value, 1 = accept |
| l2_clear | input | 1 | Readout-complete notice from the processing master |
| beam_gate | output | 1 | Beam-timed digitizer gate |
| det_gate | output | 1 | Detector-timed digitizer gate |
| l1_go | output | 1 | Start of the second-level decision |
| l2_go | output | 1 | Start to the third-level processing master |
| fe_reset | output | 1 | Front-end digitizer reset |
| dead | output | 1 | Deadtime level that freezes the trigger |

## Verification
The hardest cases to reach are the edges of the verdict window. One is a verdict that arrives while the gates are still open. Another is a verdict that coincides with the very last cycle before the timeout, where the verdict must win. A third is an accept offered in the exact cycle deadtime ends. The stimulus reaches these by following the bench's own behavioural model of the event flow and timing each input to a chosen cycle count inside the waiting phase. Stray accepts and clears are also injected during every phase of an event, and the bench confirms that nothing changes at the outputs.

// File: rtl/evt_seq_pkg.sv
package evt_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE       = 3'd0,
      PH_STROBE     = 3'd1,
      PH_WAIT_L1    = 3'd2,
      PH_L2_START   = 3'd3,
      PH_WAIT_CLEAR = 3'd4,
      PH_RESET      = 3'd5,
      PH_SETTLE     = 3'd6
   } seq_phase_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/seq_dwell_timer.sv
module seq_dwell_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   output logic [CNT_W-1:0] elapsed
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 1) begin : g_bad_width
      $error("seq_dwell_timer: CNT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  elapsed <= '0;
      else if (restart)            elapsed <= '0;
      else if (elapsed != CNT_MAX) elapsed <= elapsed + 1'b1;
   end
endmodule

// File: rtl/seq_phase_fsm.sv
module seq_phase_fsm
   import evt_seq_pkg::*;
#(
   parameter int STROBE_CYC     = 2,
   parameter int RESET_CYC      = 4,
   parameter int SETTLE_CYC     = 1400,
   parameter int L1_TIMEOUT_CYC = 1000,
   parameter bit TIMEOUT_EN     = 1'b1,
   parameter int CNT_W          = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             l0_accept,
   input  logic             l1_valid,
   input  logic             l1_pass,
   input  logic             l2_clear,
   input  logic [CNT_W-1:0] elapsed,
   output seq_phase_e       phase,
   output logic             restart
);
   localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STROBE_CYC - 1);
   localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RESET_CYC - 1);
   localparam logic [CNT_W-1:0] STL_LAST = CNT_W'(SETTLE_CYC - 1);
   localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(L1_TIMEOUT_CYC - 1);

   seq_phase_e nxt;
   logic       to_hit;

   if (TIMEOUT_EN) begin : g_to_on
      assign to_hit = (elapsed == TO_LAST);
   end else begin : g_to_off
      assign to_hit = 1'b0;
   end

   always_comb begin
      nxt = phase;
      unique case (phase)
         PH_IDLE:       if (l0_accept) nxt = PH_STROBE;
         PH_STROBE:     if (elapsed == STB_LAST) nxt = PH_WAIT_L1;
         PH_WAIT_L1: begin
            if (l1_valid)    nxt = l1_pass ? PH_L2_START : PH_RESET;
            else if (to_hit) nxt = PH_RESET;
         end
         PH_L2_START:   nxt = PH_WAIT_CLEAR;
         PH_WAIT_CLEAR: if (l2_clear) nxt = PH_RESET;
         PH_RESET:      if (elapsed == RST_LAST) nxt = PH_SETTLE;
         PH_SETTLE:     if (elapsed == STL_LAST) nxt = PH_IDLE;
         default:       nxt = PH_IDLE;
      endcase
   end

   assign restart = (nxt != phase);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= nxt;
   end
endmodule

// File: rtl/seq_out_map.sv
module seq_out_map
   import evt_seq_pkg::*;
(
   input  seq_phase_e phase,
   output logic       beam_gate,
   output logic       det_gate,
   output logic       l1_go,
   output logic       l2_go,
   output logic       fe_reset,
   output logic       dead
);
   always_comb begin
      beam_gate = (phase == PH_STROBE);
      det_gate  = (phase == PH_STROBE);
      l1_go     = (phase == PH_STROBE);
      l2_go     = (phase == PH_L2_START);
      fe_reset  = (phase == PH_RESET);
      dead      = (phase != PH_IDLE);
   end
endmodule

// File: rtl/evt_level_sequencer.sv
module evt_level_sequencer
   import evt_seq_pkg::*;
#(
   parameter int STROBE_CYC     = 2,
   parameter int RESET_CYC      = 4,
   parameter int SETTLE_CYC     = 1400,
   parameter int L1_TIMEOUT_CYC = 1000,
   parameter bit TIMEOUT_EN     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic l0_accept,
   input  logic l1_valid,
   input  logic l1_pass,
   input  logic l2_clear,
   output logic beam_gate,
   output logic det_gate,
   output logic l1_go,
   output logic l2_go,
   output logic fe_reset,
   output logic dead
);
   localparam int unsigned LONGEST =
      max2(max2(STROBE_CYC, RESET_CYC), max2(SETTLE_CYC, L1_TIMEOUT_CYC));
   localparam int CNT_W = $clog2(LONGEST + 1);

   if (STROBE_CYC < 1 || RESET_CYC < 1 || SETTLE_CYC < 1) begin : g_bad_dur
      $error("evt_level_sequencer: every duration must be at least one cycle");
   end
   if (TIMEOUT_EN && L1_TIMEOUT_CYC < 1) begin : g_bad_to
      $error("evt_level_sequencer: L1_TIMEOUT_CYC must be at least one cycle");
   end

   seq_phase_e       phase;
   logic             restart;
   logic [CNT_W-1:0] elapsed;

   seq_dwell_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(restart), .elapsed(elapsed)
   );

   seq_phase_fsm #(
      .STROBE_CYC(STROBE_CYC), .RESET_CYC(RESET_CYC), .SETTLE_CYC(SETTLE_CYC),
      .L1_TIMEOUT_CYC(L1_TIMEOUT_CYC), .TIMEOUT_EN(TIMEOUT_EN), .CNT_W(CNT_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .l0_accept(l0_accept), .l1_valid(l1_valid),
      .l1_pass(l1_pass), .l2_clear(l2_clear), .elapsed(elapsed),
      .phase(phase), .restart(restart)
   );

   seq_out_map u_map (
      .phase(phase), .beam_gate(beam_gate), .det_gate(det_gate), .l1_go(l1_go),
      .l2_go(l2_go), .fe_reset(fe_reset), .dead(dead)
   );

   // R2: an idle accept opens the gates and raises deadtime on the next cycle
   assert_accept_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!dead && l0_accept) |=> (beam_gate && det_gate && l1_go && dead));

   // R3: deadtime only ends out of the settle phase
   assert_dead_ends_in_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dead) |-> ($past(phase) == PH_SETTLE));

   // R5: a rejecting verdict goes to reset without a level-3 start
   assert_reject_resets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT_L1 && l1_valid && !l1_pass) |=> (fe_reset && !l2_go));

   // R6: the level-3 start is a single-cycle pulse
   assert_l2_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      l2_go |=> (!l2_go && dead && !fe_reset));

   // R7: the readout clear leads to the reset pulse
   assert_clear_resets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT_CLEAR && l2_clear) |=> fe_reset);

   // R8: timeout expiry without a verdict forces the reset path
   assert_timeout_resets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (TIMEOUT_EN && phase == PH_WAIT_L1 && !l1_valid &&
       elapsed == CNT_W'(L1_TIMEOUT_CYC - 1)) |=> fe_reset);

   // R11: start and reset pulses never overlap
   assert_pulses_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({l1_go, l2_go, fe_reset}));
endmodule

// File: tb/sim_evt_level_sequencer.sv
`timescale 1ns/1ps
module sim_evt_level_sequencer;
   localparam int P_STB = 2;
   localparam int P_RST = 3;
   localparam int P_STL = 20;
   localparam int P_TO  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l0_accept = 1'b0, l1_valid = 1'b0, l1_pass = 1'b0, l2_clear = 1'b0;
   logic beam_gate, det_gate, l1_go, l2_go, fe_reset, dead;

   always #2.5 clk = ~clk;

   evt_level_sequencer #(
      .STROBE_CYC(P_STB), .RESET_CYC(P_RST), .SETTLE_CYC(P_STL),
      .L1_TIMEOUT_CYC(P_TO), .TIMEOUT_EN(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .l0_accept(l0_accept), .l1_valid(l1_valid),
      .l1_pass(l1_pass), .l2_clear(l2_clear), .beam_gate(beam_gate),
      .det_gate(det_gate), .l1_go(l1_go), .l2_go(l2_go), .fe_reset(fe_reset),
      .dead(dead)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // behavioural reference: 0 idle,1 gates,2 verdict wait,3 l3 start,4 clear wait,5 reset,6 settle
   int m_ph = 0;
   int m_cnt = 0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0;
      end else begin
         int nx;
         nx = m_ph;
         case (m_ph)
            0: if (l0_accept) nx = 1;
            1: if (m_cnt + 1 >= P_STB) nx = 2;
            2: if (l1_valid) nx = l1_pass ? 3 : 5;
               else if (m_cnt + 1 >= P_TO) nx = 5;
            3: nx = 4;
            4: if (l2_clear) nx = 5;
            5: if (m_cnt + 1 >= P_RST) nx = 6;
            6: if (m_cnt + 1 >= P_STL) nx = 0;
            default: nx = 0;
         endcase
         m_cnt = (nx != m_ph) ? 0 : m_cnt + 1;
         m_ph = nx;
      end
   end

   function automatic logic [5:0] expect_out(int ph);
      logic g;
      g = (ph == 1);
      return {g, g, g, ph == 3, ph == 5, ph != 0};
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [5:0] act, exp_v;
         act   = {beam_gate, det_gate, l1_go, l2_go, fe_reset, dead};
         exp_v = expect_out(m_ph);
         n_chk++;
         if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s phase=%0d cnt=%0d actual=%b expected=%b",
                     cur_req, m_ph, m_cnt, act, exp_v);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_ph(input int p);
      while (m_ph != p) @(negedge clk);
   endtask

   task automatic accept();
      @(negedge clk); l0_accept = 1'b1;
      @(negedge clk); l0_accept = 1'b0;
   endtask

   task automatic verdict(input logic pass_v);
      l1_valid = 1'b1; l1_pass = pass_v;
      @(negedge clk); l1_valid = 1'b0; l1_pass = 1'b0;
   endtask

   task automatic readout_clear();
      l2_clear = 1'b1;
      @(negedge clk); l2_clear = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      // R1: outputs low under reset
      tick(3);
      n_chk++;
      if ({beam_gate, det_gate, l1_go, l2_go, fe_reset, dead} !== 6'b0) begin
         n_fail++;
         $display("FAIL R1 actual=%b expected=000000",
                  {beam_gate, det_gate, l1_go, l2_go, fe_reset, dead});
      end
      rst_n = 1'b1;
      tick(4);

      // R2 R6 R7: full accept path with a long readout wait
      cur_req = "R2"; accept(); wait_ph(2);
      cur_req = "R6"; tick(3); verdict(1'b1); tick(40);
      cur_req = "R7"; readout_clear(); wait_ph(0); tick(2);

      // R5: reject path
      cur_req = "R5"; accept(); wait_ph(2); tick(1); verdict(1'b0);
      cur_req = "R3"; wait_ph(0); tick(2);

      // R4: verdict offered while gates are open is ignored
      cur_req = "R4"; @(negedge clk); l0_accept = 1'b1;
      @(negedge clk); l0_accept = 1'b0; l1_valid = 1'b1; l1_pass = 1'b0;
      while (m_ph == 1) @(negedge clk);
      l1_valid = 1'b0;
      tick(2); verdict(1'b1); tick(3); readout_clear(); wait_ph(0);

      // R8: timeout with no verdict, then verdict on the last waiting cycle
      cur_req = "R8"; accept(); wait_ph(2); wait_ph(5); wait_ph(0);
      accept(); wait_ph(2); tick(P_TO - 1); verdict(1'b1); tick(2);
      readout_clear(); wait_ph(0);

      // R9: stray accepts and clears during every phase
      cur_req = "R9"; l2_clear = 1'b1; tick(3); l2_clear = 1'b0;
      accept();
      for (int k = 0; k < 12; k++) begin
         l0_accept = 1'b1; l2_clear = (m_ph != 4 && m_ph != 0); @(negedge clk);
         l0_accept = 1'b0; l2_clear = 1'b0;
         if (m_ph == 2 && k == 6) verdict(1'b1);
      end
      while (m_ph == 4) readout_clear();
      while (m_ph != 0) begin
         l0_accept = 1'b1; l2_clear = 1'b1; @(negedge clk);
         l0_accept = 1'b0; l2_clear = 1'b0;
         if (m_ph == 6 && m_cnt == P_STL - 1) break;
      end

      // R10: accept offered exactly when deadtime ends
      cur_req = "R10"; wait_ph(0); l0_accept = 1'b1; @(negedge clk);
      l0_accept = 1'b0;
      cur_req = "R11"; wait_ph(2); verdict(1'b0); wait_ph(0);
      // R10: accept in the first idle cycle of the reject path
      cur_req = "R10"; accept(); wait_ph(2); verdict(1'b0);
      while (m_ph != 0) @(negedge clk);
      l0_accept = 1'b1; @(negedge clk); l0_accept = 1'b0;
      wait_ph(2); verdict(1'b1); tick(2); readout_clear(); wait_ph(0);
      tick(5);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule